// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cluster

This block models one cluster of programmable logic. Two independent four-input lookup tables, called F and G here, each work as a 16-entry, one-bit read-only memory. A third, three-input table, H, combines the F result, the G result and one extra input. Together the three tables realise any function of five inputs. Each of the two cluster pins can show either its own four-input table or the H table. Two flip-flops each take their D input from F, G, H or a direct input that bypasses every table.

All table contents and routing choices come from one serial configuration chain. Bits are shifted in on `clk` while `cfg_en` is high. The complete set takes effect on the first rising edge of `clk` that sees `cfg_en` low after it was high. It then stays static while the cluster runs.

The flip-flops share one capture edge, which the configuration selects as rising or falling. They also share a clock enable. Each flip-flop has its own asynchronous force input, and its configuration bit makes that force a clear or a set. A global set/reset forces both flip-flops to their configured values.

Top module: `lut_cluster`

## Requirements
- R1: While `cfg_en` is 1, every rising `clk` edge shifts `cfg_din` into the configuration chain. Of the last 49 bits shifted, the first lands in the first slot of this sequence: F table entries 0..15, G entries 0..15, H entries 0..7, x pin select, y pin select, x source bit0, x source bit1, y source bit0, y source bit1, x init, y init, edge invert.
- R2: The configuration in use changes only on the first rising `clk` edge with `cfg_en` 0 after an edge with `cfg_en` 1. While bits are being shifted, the outputs keep following the old configuration. A rising edge with `rst_n` 0 clears both the chain and the configuration in use to all zeros.
- R3: The F result is F table entry number `f_in`, with `f_in[0]` as the least significant index bit. The G result is taken from `g_in` in the same way.
- R4: The H result is H table entry number {`h_in`, G result, F result}, with the F result as index bit 0.
- R5: `x_out` shows the F result when the x pin select is 0 and the H result when it is 1. `y_out` shows the G result when the y pin select is 0 and the H result when it is 1.
- R6: Each flip-flop takes D from a 2-bit source code: 0 selects F, 1 selects G, 2 selects H, 3 selects its direct input (`dx_in` for x, `dy_in` for y).
- R7: A flip-flop loads D on its capture edge only when `ce` is 1. When `ce` is 0 it keeps its value across the edge.
- R8: With edge invert 0 the flip-flops capture on the rising edge of `clk`. With edge invert 1 they capture on the falling edge.
- R9: While `sr_x` (or `sr_y`) is 1, that flip-flop is held at its init bit at once, even across capture edges. An init bit of 0 means clear and 1 means set.
- R10: While `gsr` is 1, both flip-flops are held at their init bits. This holds with the local force inputs low and with `ce` high.
- R11: With F and G fed the same four inputs, F loaded with the low half of a 32-entry truth table T, G with the high half, H with 8'hCA and the x pin select at 1, `x_out` equals T[{`h_in`, `f_in`}] for all 32 input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration and flip-flops |
| rst_n | input | 1 | Synchronous active-low reset of the configuration |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| f_in | input | 4 | F table inputs |
| g_in | input | 4 | G table inputs |
| h_in | input | 1 | Extra H table input |
| dx_in | input | 1 | Direct D input of the x flip-flop |
| dy_in | input | 1 | Direct D input of the y flip-flop |
| ce | input | 1 | Flip-flop clock enable |
| sr_x | input | 1 | Asynchronous force of the x flip-flop |
| sr_y | input | 1 | Asynchronous force of the y flip-flop |
| gsr | input | 1 | Global asynchronous set/reset |
| x_out | output | 1 | Combinational x pin |
| y_out | output | 1 | Combinational y pin |
| xq | output | 1 | x flip-flop output |
| yq | output | 1 | y flip-flop output |

## Verification
Any single configuration bit that lands in the wrong chain slot shows up combinationally on `x_out` or `y_out`. It appears as soon as the configuration takes effect and some input combination addresses the wrong entry. An error in the source code, the init bit or the edge bit shows up on `xq` or `yq` at the first capture edge after loading, or immediately when a force input is raised. A wrong or early load edge changes the pins one cycle early, or changes them while bits are still being shifted.

// File: rtl/lut_cluster_pkg.sv
// Shared types and sizes for the lookup-table cluster.
// Assumes exactly two four-input tables, one three-input combiner and two flip-flops.
package lut_cluster_pkg;
    localparam int LUT_K    = 4;
    localparam int H_K      = 3;
    localparam int N_FF     = 2;
    localparam int LUT_BITS = 1 << LUT_K;
    localparam int H_BITS   = 1 << H_K;

    typedef enum logic [1:0] {
        SRC_F      = 2'd0,
        SRC_G      = 2'd1,
        SRC_H      = 2'd2,
        SRC_DIRECT = 2'd3
    } dsrc_e;

    // Declared most significant first, so the first bit shifted in lands in f[0].
    typedef struct packed {
        logic                      clk_inv;
        logic [N_FF-1:0]           init;
        logic [N_FF-1:0][1:0]      dsrc;
        logic [N_FF-1:0]           osel;
        logic [H_BITS-1:0]         h;
        logic [LUT_BITS-1:0]       g;
        logic [LUT_BITS-1:0]       f;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);
endpackage

// File: rtl/lut_cfg_chain.sv
// Serial configuration chain with an active copy.
// Shifts cfg_din in at the top while cfg_en is high.
// Copies the chain to the active set on the first edge after cfg_en falls.
// Assumes cfg_en and cfg_din are synchronous to clk.
module lut_cfg_chain
    import lut_cluster_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_en,
    input  logic                cfg_din,
    output logic [CFG_BITS-1:0] chain_q,
    output cfg_t                active_q
);
    logic en_q;

    // Shift the serial data towards bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (cfg_en)
            chain_q <= {cfg_din, chain_q[CFG_BITS-1:1]};
    end

    // Remember the previous enable, to detect its deassertion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= cfg_en;
    end

    // Commit the chain once shifting has ended.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= '0;
        else if (en_q && !cfg_en)
            active_q <= cfg_t'(chain_q);
    end
endmodule

// File: rtl/lut_table.sv
// K-input lookup table: a 2**K by 1 read-only store indexed by idx_i.
// idx_i[0] is the least significant index bit.
module lut_table #(
    parameter int K = 4,
    localparam int DEPTH = 1 << K
) (
    input  logic [DEPTH-1:0] tbl_i,
    input  logic [K-1:0]     idx_i,
    output logic             out_o
);
    // Pick the addressed entry.
    assign out_o = tbl_i[idx_i];
endmodule

// File: rtl/lut_ff.sv
// Storage flip-flop with clock enable and an asynchronous force to a configured value.
// The force has priority over the clock.
// Assumes the caller has already applied the edge polarity to clk_i.
module lut_ff (
    input  logic clk_i,
    input  logic arst_i,
    input  logic init_i,
    input  logic ce_i,
    input  logic d_i,
    output logic q_o
);
    // Force to init, or capture D when enabled.
    always_ff @(posedge clk_i or posedge arst_i) begin
        if (arst_i)
            q_o <= init_i;
        else if (ce_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/lut_cluster.sv
// Configurable logic cluster: the F and G four-input tables, the H combiner,
// the pin routing and two flip-flops.
// Configuration arrives through lut_cfg_chain and must be static while the cluster runs.
// A flip-flop may take a spurious capture when the edge bit changes, so a global set/reset
// is expected after each configuration load.
module lut_cluster
    import lut_cluster_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h_in,
    input  logic             dx_in,
    input  logic             dy_in,
    input  logic             ce,
    input  logic             sr_x,
    input  logic             sr_y,
    input  logic             gsr,
    output logic             x_out,
    output logic             y_out,
    output logic             xq,
    output logic             yq
);
    logic [CFG_BITS-1:0] chain_q;
    cfg_t                act_cfg;
    logic                f_o, g_o, h_o;
    logic                ff_clk;
    logic [N_FF-1:0]     own_o, pin_o, dir_i, arst, dsel, q_o;

    lut_cfg_chain u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .chain_q  (chain_q),
        .active_q (act_cfg)
    );

    lut_table #(.K(LUT_K)) u_ftab (.tbl_i(act_cfg.f), .idx_i(f_in), .out_o(f_o));
    lut_table #(.K(LUT_K)) u_gtab (.tbl_i(act_cfg.g), .idx_i(g_in), .out_o(g_o));
    lut_table #(.K(H_K))   u_htab (.tbl_i(act_cfg.h), .idx_i({h_in, g_o, f_o}), .out_o(h_o));

    // Group the per-flip-flop signals so the generate loop can index them.
    assign own_o  = {g_o, f_o};
    assign dir_i  = {dy_in, dx_in};
    assign arst   = {sr_y, sr_x} | {N_FF{gsr}};
    assign ff_clk = clk ^ act_cfg.clk_inv;

    for (genvar i = 0; i < N_FF; i++) begin : g_slice
        // Pin routing: the slice's own table or the H combiner.
        always_comb begin
            pin_o[i] = act_cfg.osel[i] ? h_o : own_o[i];
        end

        // D source selection.
        always_comb begin
            case (dsrc_e'(act_cfg.dsrc[i]))
                SRC_F:   dsel[i] = f_o;
                SRC_G:   dsel[i] = g_o;
                SRC_H:   dsel[i] = h_o;
                default: dsel[i] = dir_i[i];
            endcase
        end

        lut_ff u_ff (
            .clk_i  (ff_clk),
            .arst_i (arst[i]),
            .init_i (act_cfg.init[i]),
            .ce_i   (ce),
            .d_i    (dsel[i]),
            .q_o    (q_o[i])
        );
    end

    assign x_out = pin_o[0];
    assign y_out = pin_o[1];
    assign xq    = q_o[0];
    assign yq    = q_o[1];
endmodule

// File: rtl/lut_cluster_chk.sv
// Assertion checker for lut_cluster, attached with bind.
// Observes the chain, the active configuration and the flip-flop outputs.
module lut_cluster_chk
    import lut_cluster_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_en,
    input logic                cfg_din,
    input logic                sr_x,
    input logic                sr_y,
    input logic                gsr,
    input logic                xq,
    input logic                yq,
    input logic [CFG_BITS-1:0] chain_q,
    input cfg_t                act_cfg
);
    // R1: the serial bit enters the top of the chain.
    p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (chain_q[CFG_BITS-1] == $past(cfg_din)));

    // R2: the chain is committed one edge after the enable falls.
    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_en) && $past(rst_n)) |=> (act_cfg == $past(chain_q)));

    // R2: no change to the active set while shifting continues.
    p_hold_while_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && $past(cfg_en) && $past(rst_n)) |-> $stable(act_cfg));

    // R9: the local force holds each flip-flop at its init bit.
    p_local_force_x_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_x |-> (xq == act_cfg.init[0]));
    p_local_force_y_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_y |-> (yq == act_cfg.init[1]));

    // R10: the global set/reset holds both flip-flops.
    p_global_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gsr |-> (xq == act_cfg.init[0] && yq == act_cfg.init[1]));
endmodule

bind lut_cluster lut_cluster_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .sr_x    (sr_x),
    .sr_y    (sr_y),
    .gsr     (gsr),
    .xq      (xq),
    .yq      (yq),
    .chain_q (chain_q),
    .act_cfg (act_cfg)
);

// File: tb/tb_lut_cluster.sv
`timescale 1ns/1ps
// Self-checking bench for lut_cluster: random tables, directed flip-flop cases.
module tb_lut_cluster;
    logic       clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] f_in = '0, g_in = '0;
    logic       h_in = 0, dx_in = 0, dy_in = 0, ce = 0, sr_x = 0, sr_y = 0, gsr = 0;
    logic       x_out, y_out, xq, yq;
    int         n_chk = 0, n_fail = 0;

    // Bench copy of the intended configuration.
    logic [15:0] tf, tg;
    logic [7:0]  th;
    logic        ox, oy, ix, iy, inv;
    logic [1:0]  dx, dy;
    logic        mx, my;
    logic [31:0] tt;

    lut_cluster dut (.*);

    always #4 clk = ~clk;

    task automatic chk(string req, logic act, logic expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic logic e_f(); return tf[f_in]; endfunction
    function automatic logic e_g(); return tg[g_in]; endfunction
    function automatic logic e_h(); return th[{h_in, e_g(), e_f()}]; endfunction
    function automatic logic e_x(); return ox ? e_h() : e_f(); endfunction
    function automatic logic e_y(); return oy ? e_h() : e_g(); endfunction
    function automatic logic e_d(logic [1:0] s, logic dir);
        case (s)
            2'd0: return e_f();
            2'd1: return e_g();
            2'd2: return e_h();
            default: return dir;
        endcase
    endfunction

    // Shift the configuration in the R1 sequence, then end shifting (R2 commit edge).
    task automatic load_cfg();
        logic [48:0] v;
        v = {inv, iy, ix, dy, dx, oy, ox, th, tg, tf};
        for (int i = 0; i < 49; i++) begin
            cfg_en = 1'b1; cfg_din = v[i];
            @(posedge clk); #2;
        end
        cfg_en = 1'b0;
        @(posedge clk); #2;
    endtask

    // Brief global pulse away from every clock edge, then realign to posedge+2.
    task automatic gsr_pulse(string req);
        gsr = 1'b1; #0.5;
        chk(req, xq, ix); chk(req, yq, iy);
        gsr = 1'b0;
        mx = ix; my = iy;
        @(posedge clk); #2;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        f_in = 4'hF; g_in = 4'h3; h_in = 1; #1;
        chk("R2 reset x", x_out, 1'b0); chk("R2 reset y", y_out, 1'b0);
        #1;

        // A reset edge clears a loaded configuration.
        tf = 16'hFFFF; tg = 16'hFFFF; th = 8'hFF; {ox, oy, ix, iy, inv} = '0; dx = 0; dy = 0;
        load_cfg(); #1;
        chk("R3 all-ones F", x_out, 1'b1);
        #1 rst_n = 1'b0; @(posedge clk); #2 rst_n = 1'b1; #1;
        chk("R2 reset clears x", x_out, 1'b0); chk("R2 reset clears y", y_out, 1'b0);
        #1;

        // R3/R5: own tables on the pins, independent random inputs.
        tf = $urandom; tg = $urandom; th = $urandom; ox = 0; oy = 0;
        load_cfg();
        for (int i = 0; i < 64; i++) begin
            f_in = $urandom; g_in = $urandom; h_in = $urandom; #1;
            chk("R3 R5 x=F", x_out, e_x()); chk("R3 R5 y=G", y_out, e_y());
            #1;
        end

        // R4/R5: both pins show H.
        tf = $urandom; tg = $urandom; th = $urandom; ox = 1; oy = 1;
        load_cfg();
        for (int i = 0; i < 64; i++) begin
            f_in = $urandom; g_in = $urandom; h_in = $urandom; #1;
            chk("R4 R5 x=H", x_out, e_x()); chk("R4 R5 y=H", y_out, e_y());
            #1;
        end

        // R11: any five-input function, all 32 combinations, for several tables.
        for (int t = 0; t < 4; t++) begin
            tt = (t == 0) ? 32'h8000_0001 : $urandom;
            tf = tt[15:0]; tg = tt[31:16]; th = 8'hCA; ox = 1; oy = 0;
            load_cfg();
            for (int c = 0; c < 32; c++) begin
                f_in = c[3:0]; g_in = c[3:0]; h_in = c[4]; #1;
                chk("R11 five-input", x_out, tt[c]);
                #1;
            end
        end

        // R2: shifting garbage leaves the outputs on the old configuration.
        f_in = 4'd5; g_in = 4'd5; h_in = 1'b1;
        for (int i = 0; i < 10; i++) begin
            cfg_en = 1'b1; cfg_din = ~tt[21 + i];
            @(posedge clk); #1;
            chk("R2 hold while shifting", x_out, tt[21]);
            #1;
        end
        cfg_en = 1'b0;

        // Flip-flops: x direct, y from H, x sets, y clears, rising edge.
        tf = $urandom; tg = $urandom; th = 8'h96; ox = 0; oy = 0;
        dx = 2'd3; dy = 2'd2; ix = 1; iy = 0; inv = 0; ce = 0;
        load_cfg();
        gsr_pulse("R10 global init");
        @(posedge clk); #1;
        chk("R7 hold with ce low x", xq, mx); chk("R7 hold with ce low y", yq, my);
        #1;
        for (int i = 0; i < 40; i++) begin
            f_in = $urandom; g_in = $urandom; h_in = $urandom;
            dx_in = $urandom; dy_in = $urandom; ce = $urandom; #1;
            if (ce) begin mx = e_d(dx, dx_in); my = e_d(dy, dy_in); end
            @(posedge clk); #1;
            chk("R6 R7 x capture", xq, mx); chk("R6 R7 y capture", yq, my);
            #1;
        end

        // R9: local set on x, held across an enabled edge.
        ce = 1'b1; dx_in = 1'b0;
        sr_x = 1'b1; #0.5;
        chk("R9 local set immediate", xq, 1'b1);
        @(posedge clk); #1;
        chk("R9 local set over clock", xq, 1'b1);
        #1 sr_x = 1'b0;
        // Get y to 1 through H, then clear it locally.
        h_in = ~th[{1'b0, e_g(), e_f()}];
        @(posedge clk); #1;
        chk("R6 y from H", yq, 1'b1);
        #1 ce = 1'b0;
        sr_y = 1'b1; #0.5;
        chk("R9 local clear immediate", yq, 1'b0);
        @(posedge clk); #1;
        chk("R9 local clear held", yq, 1'b0);
        #1 sr_y = 1'b0;

        // R10: global force wins over an enabled capture.
        ce = 1'b1; dx_in = 1'b0; gsr = 1'b1;
        @(posedge clk); #1;
        chk("R10 global over clock x", xq, 1'b1); chk("R10 global over clock y", yq, 1'b0);
        #1 gsr = 1'b0; ce = 1'b0;

        // R8: falling-edge capture, x from F, y from G.
        tf = 16'h5A5A; tg = 16'hA5A5; th = $urandom; dx = 2'd0; dy = 2'd1; ix = 0; iy = 1; inv = 1;
        load_cfg();
        gsr_pulse("R10 init after load");
        ce = 1'b1; f_in = 4'd1; g_in = 4'd1; #1;
        chk("R8 no capture before falling edge x", xq, 1'b0);
        chk("R8 no capture before falling edge y", yq, 1'b1);
        @(negedge clk); #1;
        chk("R8 falling capture x", xq, e_f()); chk("R8 falling capture y", yq, e_g());

        // R8: rising edge with the edge bit cleared.
        ce = 1'b0; inv = 0;
        @(posedge clk); #2;
        load_cfg();
        gsr_pulse("R10 init after reload");
        ce = 1'b1; f_in = 4'd1; g_in = 4'd1;
        @(negedge clk); #1;
        chk("R8 no capture on falling edge x", xq, 1'b0);
        chk("R8 no capture on falling edge y", yq, 1'b1);
        @(posedge clk); #1;
        chk("R8 rising capture x", xq, e_f()); chk("R8 rising capture y", yq, e_g());

        finish_run();
    end
endmodule